// File: doc/BRIEF.md
# Selective Reset and Halt Controller

This block sequences reset and halt for a small 4-bit microcontroller core and holds the core state that these two events act on. An active-high external reset and an optional power-on request are combined. The combined reset is brought onto the clock through a two-flop synchronizer. While the synchronized reset is active, only a chosen subset of the state receives start-up values: the program counter, a set of interrupt and timer flags, most of the I/O data registers and the sixteen discrete output latches. Everything else (accumulator, carry, status, timer/counter, stack and general registers, and one I/O register) keeps whatever it held before.

An active-low halt pin freezes the core. While halt is low the core clock enable is low, and no write from the core reaches any register. A build-time option decides whether the discrete outputs keep their pre-halt value or float to the released (all-ones) level during halt. The pad input register samples on every clock, whatever the halt or reset state.

The core reaches the state through a select/data write port and a combinational read port. The decoder, ALU, RAM and the analog power-on detector sit outside this block.

Top module: `selrst_halt_ctrl`

## Requirements
- R1: After the combined reset input goes low between two clock edges, `core_clk_en` stays low after the first following rising edge and goes high after the second, provided halt is released.
- R2: While reset is applied, the program counter (select 0, 12 bits) is loaded with the all-ones vector 0xFFF.
- R3: While reset is applied, the flag word (select 1, 7 bits) is loaded with 0x70. Bits 0 to 3 (external interrupt request, timer interrupt request, interrupt enable, control flag) are cleared, and bits 4 to 6 (two interrupt flags and the timer flag) are set.
- R4: While reset is applied, the discrete latches (select 2, 16 bits) become 0xFFFF and I/O registers 0 to 8 and 10 (selects 8 to 16 and 18, 4 bits each) become 0xF.
- R5: Reset leaves unchanged the accumulator (select 3, 4 bits), carry (select 4, 1 bit), status (select 5, 1 bit), timer (select 6, 8 bits), I/O register 9 (select 17), stack entries 0 to 3 (selects 20 to 23, 12 bits) and general registers 0 to 3 (selects 24 to 27, 4 bits).
- R6: With the power-on source enabled, `por_req` resets the block exactly as `ext_rst` does. With it disabled, `por_req` has no effect.
- R7: While `halt_n` is low, `core_clk_en` is low, writes are ignored and all held state, the program counter included, keeps its value.
- R8: Reset has priority over halt. A reset during halt loads the start-up values, and `core_clk_en` stays low until `halt_n` returns high.
- R9: During halt, `dlatch_o` shows the latch contents when output hold is enabled and 0xFFFF when it is disabled.
- R10: `din_o` shows the value `pad_in` had at the previous rising edge, in halt and in reset alike.
- R11: When `core_clk_en` is high, a write with `wr_en` stores the low bits of `wr_data` that fit the selected register. Reads return the register zero-extended, and unused selects (7, 19, 28 to 31) read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| ext_rst | input | 1 | External reset, active high, asynchronous |
| por_req | input | 1 | Power-on reset request, active high |
| halt_n | input | 1 | Halt request, active low |
| wr_en | input | 1 | Core write strobe |
| wr_sel | input | 5 | Register select for writes |
| wr_data | input | 16 | Write data, low bits used |
| rd_sel | input | 5 | Register select for reads |
| rd_data | output | 16 | Selected register, zero-extended |
| pad_in | input | 16 | Pad input levels |
| core_clk_en | output | 1 | Clock enable for the core |
| pc_o | output | 12 | Program counter |
| dlatch_o | output | 16 | Discrete output latches after halt treatment |
| din_o | output | 16 | Registered pad inputs |

## Verification
The properties assume that `halt_n` is already synchronous to the clock. They also assume that the core writes only when it sees `core_clk_en` high, so a write on a frozen cycle has to be dropped. The power-on and external resets may arrive at any time, but each pulse must span at least one rising edge. The stimulus changes every input at the falling edge, holds each reset for three cycles and takes random values only for write data and pad levels, so that these conditions always hold.

// File: rtl/selrst_pkg.sv
package selrst_pkg;

    // Select codes that the core's register-access decoder depends on.
    localparam int unsigned SEL_W       = 5;
    localparam int unsigned SEL_PC      = 0;
    localparam int unsigned SEL_FLAGS   = 1;
    localparam int unsigned SEL_DLATCH  = 2;
    localparam int unsigned SEL_ACC     = 3;
    localparam int unsigned SEL_CARRY   = 4;
    localparam int unsigned SEL_STATUS  = 5;
    localparam int unsigned SEL_TIMER   = 6;
    localparam int unsigned SEL_IO_BASE = 8;

    // Flag word layout.
    localparam int unsigned FLG_W       = 7;
    localparam int unsigned FLG_IRQ_EXT = 0;
    localparam int unsigned FLG_IRQ_TMR = 1;
    localparam int unsigned FLG_IRQ_EN  = 2;
    localparam int unsigned FLG_CTRL    = 3;
    localparam int unsigned FLG_INT0    = 4;
    localparam int unsigned FLG_INT1    = 5;
    localparam int unsigned FLG_TMR     = 6;

    localparam logic [FLG_W-1:0] FLG_PRESET =
        FLG_W'((1 << FLG_INT0) | (1 << FLG_INT1) | (1 << FLG_TMR));

endpackage

// File: rtl/selrst_sync.sv
module selrst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_raw,
    output logic rst_sync
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b0};
    end

    // Asynchronous assertion, synchronous release.
    always_ff @(posedge clk or posedge rst_raw) begin
        if (rst_raw) sync_q <= '1;
        else         sync_q <= sync_d;
    end

    assign rst_sync = sync_q[STAGES-1];
endmodule

// File: rtl/selrst_state.sv
module selrst_state
    import selrst_pkg::*;
#(
    parameter int unsigned PC_W     = 12,
    parameter int unsigned DW       = 4,
    parameter int unsigned TMR_W    = 8,
    parameter int unsigned N_IO     = 11,
    parameter int unsigned N_DL     = 16,
    parameter int unsigned N_STK    = 4,
    parameter int unsigned N_GR     = 4,
    parameter int unsigned RW       = 16,
    parameter logic [N_IO-1:0] IO_PRESET_MASK = 11'b101_1111_1111
) (
    input  logic             clk,
    input  logic             rst_i,
    input  logic             clk_en_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [RW-1:0]    wr_data_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [RW-1:0]    rd_data_o,
    input  logic [N_DL-1:0]  pad_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [N_DL-1:0]  dlatch_o,
    output logic [N_DL-1:0]  din_o
);
    localparam int unsigned SEL_STK_BASE = SEL_IO_BASE + N_IO + 1;
    localparam int unsigned SEL_GR_BASE  = SEL_STK_BASE + N_STK;

    typedef struct packed {
        logic [PC_W-1:0]             pc;
        logic [FLG_W-1:0]            flg;
        logic [N_DL-1:0]             dl;
        logic [DW-1:0]               acc;
        logic                        carry;
        logic                        status;
        logic [TMR_W-1:0]            tmr;
        logic [N_IO-1:0][DW-1:0]     io;
        logic [N_STK-1:0][PC_W-1:0]  stk;
        logic [N_GR-1:0][DW-1:0]     gr;
        logic [N_DL-1:0]             din;
    } state_t;

    state_t st_d, st_q;

    // Next-state: pads always sampled, reset presets a subset, core writes otherwise.
    always_comb begin
        st_d     = st_q;
        st_d.din = pad_i;
        if (rst_i) begin
            st_d.pc  = '1;
            st_d.flg = FLG_PRESET;
            st_d.dl  = '1;
            for (int i = 0; i < N_IO; i++) begin
                if (IO_PRESET_MASK[i]) st_d.io[i] = '1;
            end
        end else if (clk_en_i && wr_en_i) begin
            if (wr_sel_i == SEL_W'(SEL_PC))     st_d.pc     = wr_data_i[PC_W-1:0];
            if (wr_sel_i == SEL_W'(SEL_FLAGS))  st_d.flg    = wr_data_i[FLG_W-1:0];
            if (wr_sel_i == SEL_W'(SEL_DLATCH)) st_d.dl     = wr_data_i[N_DL-1:0];
            if (wr_sel_i == SEL_W'(SEL_ACC))    st_d.acc    = wr_data_i[DW-1:0];
            if (wr_sel_i == SEL_W'(SEL_CARRY))  st_d.carry  = wr_data_i[0];
            if (wr_sel_i == SEL_W'(SEL_STATUS)) st_d.status = wr_data_i[0];
            if (wr_sel_i == SEL_W'(SEL_TIMER))  st_d.tmr    = wr_data_i[TMR_W-1:0];
            for (int i = 0; i < N_IO; i++) begin
                if (wr_sel_i == SEL_W'(SEL_IO_BASE + i)) st_d.io[i] = wr_data_i[DW-1:0];
            end
            for (int i = 0; i < N_STK; i++) begin
                if (wr_sel_i == SEL_W'(SEL_STK_BASE + i)) st_d.stk[i] = wr_data_i[PC_W-1:0];
            end
            for (int i = 0; i < N_GR; i++) begin
                if (wr_sel_i == SEL_W'(SEL_GR_BASE + i)) st_d.gr[i] = wr_data_i[DW-1:0];
            end
        end
    end

    // No reset on purpose: only the preset subset above is initialised.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i == SEL_W'(SEL_PC))     rd_data_o = RW'(st_q.pc);
        if (rd_sel_i == SEL_W'(SEL_FLAGS))  rd_data_o = RW'(st_q.flg);
        if (rd_sel_i == SEL_W'(SEL_DLATCH)) rd_data_o = RW'(st_q.dl);
        if (rd_sel_i == SEL_W'(SEL_ACC))    rd_data_o = RW'(st_q.acc);
        if (rd_sel_i == SEL_W'(SEL_CARRY))  rd_data_o = RW'(st_q.carry);
        if (rd_sel_i == SEL_W'(SEL_STATUS)) rd_data_o = RW'(st_q.status);
        if (rd_sel_i == SEL_W'(SEL_TIMER))  rd_data_o = RW'(st_q.tmr);
        for (int i = 0; i < N_IO; i++) begin
            if (rd_sel_i == SEL_W'(SEL_IO_BASE + i)) rd_data_o = RW'(st_q.io[i]);
        end
        for (int i = 0; i < N_STK; i++) begin
            if (rd_sel_i == SEL_W'(SEL_STK_BASE + i)) rd_data_o = RW'(st_q.stk[i]);
        end
        for (int i = 0; i < N_GR; i++) begin
            if (rd_sel_i == SEL_W'(SEL_GR_BASE + i)) rd_data_o = RW'(st_q.gr[i]);
        end
    end

    assign pc_o     = st_q.pc;
    assign dlatch_o = st_q.dl;
    assign din_o    = st_q.din;
endmodule

// File: rtl/selrst_out_stage.sv
module selrst_out_stage #(
    parameter int unsigned N_DL     = 16,
    parameter bit          HOLD_OUT = 1'b1
) (
    input  logic            halted_i,
    input  logic [N_DL-1:0] latch_i,
    output logic [N_DL-1:0] pad_o
);
    generate
        if (HOLD_OUT) begin : g_hold
            assign pad_o = latch_i;
        end else begin : g_release
            logic [N_DL-1:0] out_d;
            always_comb begin
                out_d = latch_i;
                if (halted_i) out_d = '1;
            end
            assign pad_o = out_d;
        end
    endgenerate
endmodule

// File: rtl/selrst_halt_ctrl.sv
module selrst_halt_ctrl
    import selrst_pkg::*;
#(
    parameter bit          POR_EN   = 1'b1,
    parameter bit          HOLD_OUT = 1'b1,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PC_W     = 12,
    parameter int unsigned DW       = 4,
    parameter int unsigned TMR_W    = 8,
    parameter int unsigned N_IO     = 11,
    parameter int unsigned N_DL     = 16,
    parameter int unsigned N_STK    = 4,
    parameter int unsigned N_GR     = 4,
    parameter int unsigned RW       = 16
) (
    input  logic             clk,
    input  logic             ext_rst,
    input  logic             por_req,
    input  logic             halt_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [RW-1:0]    wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [RW-1:0]    rd_data,
    input  logic [N_DL-1:0]  pad_in,
    output logic             core_clk_en,
    output logic [PC_W-1:0]  pc_o,
    output logic [N_DL-1:0]  dlatch_o,
    output logic [N_DL-1:0]  din_o
);
    logic rst_raw;
    logic rst_sync;
    logic [N_DL-1:0] latch_q;

    generate
        if (POR_EN) begin : g_por
            assign rst_raw = ext_rst | por_req;
        end else begin : g_no_por
            logic por_unused;
            assign por_unused = por_req;
            assign rst_raw    = ext_rst;
        end
    endgenerate

    selrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_raw  (rst_raw),
        .rst_sync (rst_sync)
    );

    // Reset wins over halt; either one keeps the core frozen.
    assign core_clk_en = halt_n & ~rst_sync;

    selrst_state #(
        .PC_W (PC_W), .DW (DW), .TMR_W (TMR_W), .N_IO (N_IO),
        .N_DL (N_DL), .N_STK (N_STK), .N_GR (N_GR), .RW (RW)
    ) u_state (
        .clk       (clk),
        .rst_i     (rst_sync),
        .clk_en_i  (core_clk_en),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .pad_i     (pad_in),
        .pc_o      (pc_o),
        .dlatch_o  (latch_q),
        .din_o     (din_o)
    );

    selrst_out_stage #(.N_DL(N_DL), .HOLD_OUT(HOLD_OUT)) u_out (
        .halted_i (~halt_n),
        .latch_i  (latch_q),
        .pad_o    (dlatch_o)
    );
endmodule

// File: rtl/selrst_halt_sva.sv
module selrst_halt_sva #(
    parameter bit          HOLD_OUT = 1'b1,
    parameter int unsigned PC_W     = 12,
    parameter int unsigned N_DL     = 16
) (
    input logic            clk,
    input logic            rst_sync,
    input logic            halt_n,
    input logic            core_clk_en,
    input logic [PC_W-1:0] pc_o,
    input logic [N_DL-1:0] dlatch_o,
    input logic [N_DL-1:0] pad_in,
    input logic [N_DL-1:0] din_o
);
    a_r7_halt_freezes_clock: assert property (@(posedge clk) disable iff (rst_sync)
        !halt_n |-> !core_clk_en);

    a_r7_pc_held_in_halt: assert property (@(posedge clk) disable iff (rst_sync)
        !halt_n |=> $stable(pc_o));

    a_r8_reset_blocks_clock: assert property (@(posedge clk)
        rst_sync |-> !core_clk_en);

    a_r2_pc_vector_on_release: assert property (@(posedge clk) disable iff (rst_sync)
        $fell(rst_sync) |-> pc_o == '1);

    a_r9_released_outputs: assert property (@(posedge clk) disable iff (rst_sync)
        (!halt_n && !HOLD_OUT) |-> dlatch_o == '1);

    a_r10_pads_sampled: assert property (@(posedge clk) disable iff (rst_sync)
        !halt_n |=> din_o == $past(pad_in));
endmodule

bind selrst_halt_ctrl selrst_halt_sva #(
    .HOLD_OUT (HOLD_OUT), .PC_W (PC_W), .N_DL (N_DL)
) u_sva (
    .clk         (clk),
    .rst_sync    (rst_sync),
    .halt_n      (halt_n),
    .core_clk_en (core_clk_en),
    .pc_o        (pc_o),
    .dlatch_o    (dlatch_o),
    .pad_in      (pad_in),
    .din_o       (din_o)
);

// File: tb/selrst_halt_ctrl_tb_top.sv
module selrst_halt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        ext_rst = 1'b0, por_req = 1'b0, halt_n = 1'b1, wr_en = 1'b0;
    logic [4:0]  wr_sel = '0, rd_sel = '0;
    logic [15:0] wr_data = '0, pad_in = '0;
    logic [15:0] rd_data, rd_data_lp, dl_o, dl_o_lp, din_o, din_o_lp;
    logic [11:0] pc_o, pc_o_lp;
    logic        clk_en, clk_en_lp;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdl [0:31];

    always #2.5 clk = ~clk;

    selrst_halt_ctrl dut_i (
        .clk(clk), .ext_rst(ext_rst), .por_req(por_req), .halt_n(halt_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .pad_in(pad_in), .core_clk_en(clk_en),
        .pc_o(pc_o), .dlatch_o(dl_o), .din_o(din_o));

    selrst_halt_ctrl #(.POR_EN(1'b0), .HOLD_OUT(1'b0)) dut_lp (
        .clk(clk), .ext_rst(ext_rst), .por_req(por_req), .halt_n(halt_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data_lp), .pad_in(pad_in), .core_clk_en(clk_en_lp),
        .pc_o(pc_o_lp), .dlatch_o(dl_o_lp), .din_o(din_o_lp));

    function automatic logic [15:0] wmask(input int sel);
        case (sel)
            0: return 16'h0FFF;
            1: return 16'h007F;
            2: return 16'hFFFF;
            3: return 16'h000F;
            4, 5: return 16'h0001;
            6: return 16'h00FF;
            default: begin
                if (sel >= 8 && sel <= 18) return 16'h000F;
                if (sel >= 20 && sel <= 23) return 16'h0FFF;
                if (sel >= 24 && sel <= 27) return 16'h000F;
                return 16'h0000;
            end
        endcase
    endfunction

    function automatic logic [15:0] after_reset(input int sel, input logic [15:0] old);
        if (sel == 0) return 16'h0FFF;
        if (sel == 1) return 16'h0070;
        if (sel == 2) return 16'hFFFF;
        if ((sel >= 8 && sel <= 16) || sel == 18) return 16'h000F;
        return old;
    endfunction

    function automatic string req_of(input int sel);
        if (sel == 0) return "R2";
        if (sel == 1) return "R3";
        if (sel == 2 || (sel >= 8 && sel <= 16) || sel == 18) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'(sel); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input int sel, input logic [15:0] exp);
        rd_sel = 5'(sel);
        #1;
        check(req, rd_data, exp);
    endtask

    // Pulse one reset source for three cycles and check release timing (R1).
    task automatic pulse_reset(input bit use_por);
        @(negedge clk);
        if (use_por) por_req = 1'b1; else ext_rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during", {15'd0, clk_en}, 16'd0);
        ext_rst = 1'b0; por_req = 1'b0;
        @(negedge clk);
        check("R1 first edge", {15'd0, clk_en}, 16'd0);
        @(negedge clk);
        check("R1 second edge", {15'd0, clk_en}, 16'd1);
        for (int s = 0; s < 32; s++) mdl[s] = after_reset(s, mdl[s]);
    endtask

    task automatic check_all(input string tag);
        for (int s = 0; s < 32; s++) begin
            read_chk(wmask(s) == 0 ? "R11" : req_of(s), s, mdl[s]);
        end
        check({tag, " R2 pc port"}, {4'd0, pc_o}, mdl[0]);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pc_before, v;
        void'($urandom(32'd20240611));
        for (int s = 0; s < 32; s++) mdl[s] = '0;
        #1 ext_rst = 1'b1;
        repeat (3) @(negedge clk);
        // Reset state: presets visible, clock enable low.
        check("R1 reset state", {15'd0, clk_en}, 16'd0);
        check("R2 reset pc", {4'd0, pc_o}, 16'h0FFF);
        ext_rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 released", {15'd0, clk_en}, 16'd1);
        read_chk("R3", 1, 16'h0070);
        read_chk("R4", 2, 16'hFFFF);
        read_chk("R4", 10, 16'h000F);

        // Random fills followed by resets from alternating sources.
        for (int round = 0; round < 4; round++) begin
            for (int s = 0; s < 32; s++) begin
                v = 16'($urandom);
                do_write(s, v);
                if (wmask(s) != 0) mdl[s] = v & wmask(s);
            end
            check_all("R11 fill");
            pc_before = mdl[0];
            pulse_reset(round % 2 == 1);
            check_all("after reset");
            if (round % 2 == 1) begin
                // R6: power-on request ignored when disabled.
                check("R6 lp pc kept", {4'd0, pc_o_lp}, pc_before);
            end else begin
                check("R6 lp pc reset", {4'd0, pc_o_lp}, 16'h0FFF);
            end
        end

        // Halt: frozen clock, writes ignored, outputs per option, pads sampled.
        do_write(2, 16'h1234); mdl[2] = 16'h1234;
        do_write(0, 16'h0ABC); mdl[0] = 16'h0ABC;
        @(negedge clk);
        halt_n = 1'b0;
        #1;
        check("R7 clk_en low", {15'd0, clk_en}, 16'd0);
        check("R9 hold", dl_o, 16'h1234);
        check("R9 release", dl_o_lp, 16'hFFFF);
        do_write(0, 16'h0555);
        do_write(24, 16'h0009);
        for (int k = 0; k < 6; k++) begin
            pad_in = 16'($urandom);
            v = pad_in;
            @(negedge clk);
            check("R10 pads in halt", din_o, v);
        end
        check("R7 pc held", {4'd0, pc_o}, 16'h0ABC);
        @(negedge clk);
        halt_n = 1'b1;
        #1;
        check("R7 clk_en back", {15'd0, clk_en}, 16'd1);
        read_chk("R7", 0, mdl[0]);
        read_chk("R7", 24, mdl[24]);
        check("R9 lp after halt", dl_o_lp, 16'h1234);

        // Reset during halt (R8).
        do_write(3, 16'h0006); mdl[3] = 16'h0006;
        @(negedge clk);
        halt_n = 1'b0; ext_rst = 1'b1;
        repeat (3) @(negedge clk);
        ext_rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 clk_en held", {15'd0, clk_en}, 16'd0);
        for (int s = 0; s < 32; s++) mdl[s] = after_reset(s, mdl[s]);
        read_chk("R8", 0, 16'h0FFF);
        read_chk("R8", 3, 16'h0006);
        pad_in = 16'hA5C3;
        @(negedge clk);
        check("R10 pads", din_o, 16'hA5C3);
        halt_n = 1'b1;
        #1;
        check("R8 clk_en after halt", {15'd0, clk_en}, 16'd1);
        check_all("final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule